// File: doc/BRIEF.md
# Tomasulo Dispatch and Issue Core

This block is a compact out-of-order execution engine. Decoded arithmetic operations arrive one per cycle, strictly in program order, each carrying an opcode (add or multiply), a destination register and two source registers. Each accepted operation is placed in a reservation station belonging to its functional unit. A register alias table renames destinations, so every source is captured either as a value or as the tag of the station that will produce it. Waiting stations watch a single result bus and take operand values from it as they appear.

Ready stations are started on a fully pipelined adder or multiplier. When both units pick, each starts its oldest ready operation. Finished results share one broadcast bus. The bus updates waiting stations and the register file, and it is also the block's output: each writeback event carries the producer tag, the destination register and the value. When the target unit has no free station, the block raises a stall and does not accept the offered operation.

Top module: `tomasulo_core`

## Requirements
- R1: After reset no writeback is reported, stall is low, and architectural register k holds the value k.
- R2: An operation offered with in_valid is accepted at the clock edge unless stall is high. Stall is high exactly when in_valid is high and every station of the target unit is busy.
- R3: An accepted operation takes the lowest-numbered free station of its unit. Its tag is a 3-bit value: bit 2 is the unit (0 adder, 1 multiplier) and bits 1:0 are the station index. The adder has stations 0 to 2 and the multiplier has stations 0 and 1.
- R4: An add whose operands are available when it is accepted in cycle c is written back in cycle c+3. A multiply in the same situation is written back in cycle c+5.
- R5: An add produces the sum of its two operands modulo 2^16, and a multiply produces the low 16 bits of the product. Results and destination registers match sequential execution in program order.
- R6: An operation that waits on a result starts in the cycle after that result is broadcast. This includes a result broadcast in the same cycle the operation is accepted.
- R7: When several stations of one unit are ready, the oldest operation in program order starts first, whatever its station number.
- R8: When both units finish in the same cycle, the older operation uses the bus. The younger one is written back one cycle later.
- R9: A register is updated by a writeback only while its alias entry still names that tag. A later write to the same register is never overwritten by an older producer that finishes afterwards.
- R10: A station becomes free in its writeback cycle and can accept a new operation in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered this cycle |
| in_op | input | 1 | 0 = add, 1 = multiply |
| in_dst | input | 3 | Destination register |
| in_src1 | input | 3 | First source register |
| in_src2 | input | 3 | Second source register |
| stall | output | 1 | Offered operation not accepted: no free station in its unit |
| wb_valid | output | 1 | A result is on the broadcast bus |
| wb_tag | output | 3 | Tag of the producing station |
| wb_reg | output | 3 | Destination register of the result |
| wb_value | output | 16 | Result value |

## Verification
The hardest situations to reach from the ports are those where the older of two ready stations sits in the higher station, and where the two units finish in the same cycle. The bench reaches the first by letting a short add free station 0 while a dependent add waits in station 1, and then dispatching a second dependent into station 0 in the same cycle the shared producer broadcasts. It reaches the second by spacing a multiply and an add, or an add that waits on a multiply, so that both finish together, in either age order. A long pseudo-random sweep then checks every writeback against an in-order architectural model and checks every stall decision against the bench's own count of stations in use.

// File: rtl/tomasulo_pkg.sv
package tomasulo_pkg;

    // sequence number width; in-flight operations must stay below 2**(SEQ_W-1)
    localparam int SEQ_W = 6;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_MUL = 1'b1
    } op_e;

    // a is older than b under modular sequence numbering
    function automatic logic seq_older(input logic [SEQ_W-1:0] a,
                                       input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] diff;
        diff = a - b;
        return diff[SEQ_W-1];
    endfunction

endpackage

// File: rtl/exec_pipe.sv
module exec_pipe #(
    parameter int LAT = 2,
    parameter int PW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          in_valid,
    input  logic [PW-1:0] in_data,
    output logic          out_valid,
    output logic [PW-1:0] out_data
);

    logic [LAT-1:0]         vld_d, vld_q;
    logic [LAT-1:0][PW-1:0] dat_d, dat_q;

    always_comb begin
        vld_d = vld_q;
        dat_d = dat_q;
        if (!hold) begin
            vld_d[0] = in_valid;
            dat_d[0] = in_data;
            for (int s = 1; s < LAT; s++) begin
                vld_d[s] = vld_q[s-1];
                dat_d[s] = dat_q[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            dat_q <= '0;
        end else begin
            vld_q <= vld_d;
            dat_q <= dat_d;
        end
    end

    assign out_valid = vld_q[LAT-1];
    assign out_data  = dat_q[LAT-1];

endmodule

// File: rtl/oldest_pick.sv
module oldest_pick
    import tomasulo_pkg::*;
#(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic [N-1:0]            ready,
    input  logic [N-1:0][SEQ_W-1:0] seq,
    output logic                    found,
    output logic [IW-1:0]           idx
);

    logic [SEQ_W-1:0] best_seq;

    always_comb begin
        found    = 1'b0;
        idx      = '0;
        best_seq = '0;
        for (int i = 0; i < N; i++) begin
            if (ready[i] && (!found || seq_older(seq[i], best_seq))) begin
                found    = 1'b1;
                idx      = IW'(i);
                best_seq = seq[i];
            end
        end
    end

endmodule

// File: rtl/tomasulo_core.sv
module tomasulo_core
    import tomasulo_pkg::*;
#(
    parameter  int DATA_W   = 16,
    parameter  int NUM_REGS = 8,
    parameter  int ADD_RS   = 3,
    parameter  int MUL_RS   = 2,
    parameter  int ADD_LAT  = 2,
    parameter  int MUL_LAT  = 4,
    localparam int REG_W    = $clog2(NUM_REGS),
    localparam int MAX_RS   = (ADD_RS > MUL_RS) ? ADD_RS : MUL_RS,
    localparam int IDX_W    = $clog2(MAX_RS),
    localparam int TAG_W    = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_op,
    input  logic [REG_W-1:0]  in_dst,
    input  logic [REG_W-1:0]  in_src1,
    input  logic [REG_W-1:0]  in_src2,
    output logic              stall,
    output logic              wb_valid,
    output logic [TAG_W-1:0]  wb_tag,
    output logic [REG_W-1:0]  wb_reg,
    output logic [DATA_W-1:0] wb_value
);

    localparam int NUM_RS = ADD_RS + MUL_RS;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic              v;
        logic [DATA_W-1:0] x;
    } opnd_t;

    typedef struct packed {
        logic             busy;
        logic             issued;
        logic [REG_W-1:0] dst;
        logic [SEQ_W-1:0] seq;
        opnd_t            a;
        opnd_t            b;
    } rs_t;

    typedef struct packed {
        logic              rdy;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } rat_t;

    typedef struct packed {
        rs_t  [NUM_RS-1:0]   rs;
        rat_t [NUM_REGS-1:0] rat;
        logic [SEQ_W-1:0]    seq;
    } state_t;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [REG_W-1:0]  dst;
        logic [SEQ_W-1:0]  seq;
        logic [DATA_W-1:0] val;
    } res_t;

    function automatic logic [TAG_W-1:0] tag_of(input int s);
        if (s < ADD_RS) return {1'b0, IDX_W'(s)};
        return {1'b1, IDX_W'(s - ADD_RS)};
    endfunction

    function automatic int slot_of(input logic [TAG_W-1:0] t);
        if (t[TAG_W-1]) return ADD_RS + int'(t[IDX_W-1:0]);
        return int'(t[IDX_W-1:0]);
    endfunction

    function automatic opnd_t read_src(input rat_t e, input logic bv, input res_t bres);
        opnd_t o;
        o.tag = e.tag;
        o.v   = e.rdy || (bv && bres.tag == e.tag);
        o.x   = e.rdy ? e.val : bres.val;
        return o;
    endfunction

    state_t st_d, st_q;

    // result bus arbitration
    logic a_out_v, m_out_v, pick_m, bc_v, a_hold, m_hold;
    res_t a_out, m_out, bc;

    assign pick_m = m_out_v && (!a_out_v || seq_older(m_out.seq, a_out.seq));
    assign bc_v   = a_out_v || m_out_v;
    assign bc     = pick_m ? m_out : a_out;
    assign a_hold = a_out_v && pick_m;
    assign m_hold = m_out_v && !pick_m;

    assign wb_valid = bc_v;
    assign wb_tag   = bc.tag;
    assign wb_reg   = bc.dst;
    assign wb_value = bc.val;

    // per-unit selection
    logic [ADD_RS-1:0]            a_rdy;
    logic [MUL_RS-1:0]            m_rdy;
    logic [ADD_RS-1:0][SEQ_W-1:0] a_seqs;
    logic [MUL_RS-1:0][SEQ_W-1:0] m_seqs;
    logic                         a_found, m_found, a_issue, m_issue;
    logic [IDX_W-1:0]             a_idx, m_idx;
    logic [NUM_RS-1:0]            rs_busy;

    always_comb begin
        for (int i = 0; i < NUM_RS; i++) begin
            rs_busy[i] = st_q.rs[i].busy;
        end
        for (int i = 0; i < ADD_RS; i++) begin
            a_rdy[i]  = st_q.rs[i].busy && !st_q.rs[i].issued && st_q.rs[i].a.v && st_q.rs[i].b.v;
            a_seqs[i] = st_q.rs[i].seq;
        end
        for (int i = 0; i < MUL_RS; i++) begin
            m_rdy[i]  = st_q.rs[ADD_RS+i].busy && !st_q.rs[ADD_RS+i].issued
                        && st_q.rs[ADD_RS+i].a.v && st_q.rs[ADD_RS+i].b.v;
            m_seqs[i] = st_q.rs[ADD_RS+i].seq;
        end
    end

    oldest_pick #(.N(ADD_RS), .IW(IDX_W)) u_add_pick (
        .ready(a_rdy), .seq(a_seqs), .found(a_found), .idx(a_idx)
    );
    oldest_pick #(.N(MUL_RS), .IW(IDX_W)) u_mul_pick (
        .ready(m_rdy), .seq(m_seqs), .found(m_found), .idx(m_idx)
    );

    assign a_issue = a_found && !a_hold;
    assign m_issue = m_found && !m_hold;

    res_t a_in, m_in;
    int   a_slot, m_slot;

    always_comb begin
        a_slot     = int'(a_idx);
        m_slot     = ADD_RS + int'(m_idx);
        a_in.tag   = tag_of(a_slot);
        a_in.dst   = st_q.rs[a_slot].dst;
        a_in.seq   = st_q.rs[a_slot].seq;
        a_in.val   = st_q.rs[a_slot].a.x + st_q.rs[a_slot].b.x;
        m_in.tag   = tag_of(m_slot);
        m_in.dst   = st_q.rs[m_slot].dst;
        m_in.seq   = st_q.rs[m_slot].seq;
        m_in.val   = st_q.rs[m_slot].a.x * st_q.rs[m_slot].b.x;
    end

    exec_pipe #(.LAT(ADD_LAT), .PW($bits(res_t))) u_add_pipe (
        .clk(clk), .rst_n(rst_n), .hold(a_hold), .in_valid(a_issue),
        .in_data(a_in), .out_valid(a_out_v), .out_data(a_out)
    );
    exec_pipe #(.LAT(MUL_LAT), .PW($bits(res_t))) u_mul_pipe (
        .clk(clk), .rst_n(rst_n), .hold(m_hold), .in_valid(m_issue),
        .in_data(m_in), .out_valid(m_out_v), .out_data(m_out)
    );

    // first free station per unit, lowest index wins
    logic a_free_any, m_free_any;
    int   a_free_idx, m_free_idx;

    always_comb begin
        a_free_any = 1'b0;
        a_free_idx = 0;
        for (int i = ADD_RS - 1; i >= 0; i--) begin
            if (!st_q.rs[i].busy) begin
                a_free_any = 1'b1;
                a_free_idx = i;
            end
        end
        m_free_any = 1'b0;
        m_free_idx = ADD_RS;
        for (int i = MUL_RS - 1; i >= 0; i--) begin
            if (!st_q.rs[ADD_RS+i].busy) begin
                m_free_any = 1'b1;
                m_free_idx = ADD_RS + i;
            end
        end
    end

    assign stall = in_valid && ((in_op == OP_MUL) ? !m_free_any : !a_free_any);

    int new_slot;

    always_comb begin
        st_d     = st_q;
        new_slot = (in_op == OP_MUL) ? m_free_idx : a_free_idx;
        if (a_issue) st_d.rs[a_slot].issued = 1'b1;
        if (m_issue) st_d.rs[m_slot].issued = 1'b1;
        if (bc_v) begin
            for (int s = 0; s < NUM_RS; s++) begin
                if (st_q.rs[s].busy && !st_q.rs[s].a.v && st_q.rs[s].a.tag == bc.tag) begin
                    st_d.rs[s].a.v = 1'b1;
                    st_d.rs[s].a.x = bc.val;
                end
                if (st_q.rs[s].busy && !st_q.rs[s].b.v && st_q.rs[s].b.tag == bc.tag) begin
                    st_d.rs[s].b.v = 1'b1;
                    st_d.rs[s].b.x = bc.val;
                end
            end
            for (int r = 0; r < NUM_REGS; r++) begin
                if (!st_q.rat[r].rdy && st_q.rat[r].tag == bc.tag) begin
                    st_d.rat[r].rdy = 1'b1;
                    st_d.rat[r].val = bc.val;
                end
            end
            st_d.rs[slot_of(bc.tag)].busy   = 1'b0;
            st_d.rs[slot_of(bc.tag)].issued = 1'b0;
        end
        if (in_valid && !stall) begin
            st_d.rs[new_slot].busy   = 1'b1;
            st_d.rs[new_slot].issued = 1'b0;
            st_d.rs[new_slot].dst    = in_dst;
            st_d.rs[new_slot].seq    = st_q.seq;
            st_d.rs[new_slot].a      = read_src(st_q.rat[in_src1], bc_v, bc);
            st_d.rs[new_slot].b      = read_src(st_q.rat[in_src2], bc_v, bc);
            st_d.rat[in_dst].rdy     = 1'b0;
            st_d.rat[in_dst].tag     = tag_of(new_slot);
            st_d.seq                 = st_q.seq + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int r = 0; r < NUM_REGS; r++) begin
                st_q.rat[r].rdy <= 1'b1;
                st_q.rat[r].val <= DATA_W'(r);
            end
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tomasulo_core_chk.sv
module tomasulo_core_chk #(
    parameter int ADD_RS = 3,
    parameter int MUL_RS = 2,
    parameter int TAG_W  = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     in_op,
    input logic                     stall,
    input logic                     wb_valid,
    input logic [TAG_W-1:0]         wb_tag,
    input logic [ADD_RS+MUL_RS-1:0] busy
);

    int add_cnt_d, add_cnt_q, mul_cnt_d, mul_cnt_q, wb_slot;
    logic accept;

    always_comb begin
        accept    = in_valid && !stall;
        add_cnt_d = add_cnt_q;
        mul_cnt_d = mul_cnt_q;
        if (accept && !in_op) add_cnt_d = add_cnt_d + 1;
        if (accept &&  in_op) mul_cnt_d = mul_cnt_d + 1;
        if (wb_valid && !wb_tag[TAG_W-1]) add_cnt_d = add_cnt_d - 1;
        if (wb_valid &&  wb_tag[TAG_W-1]) mul_cnt_d = mul_cnt_d - 1;
        wb_slot = wb_tag[TAG_W-1] ? ADD_RS + int'(wb_tag[TAG_W-2:0]) : int'(wb_tag[TAG_W-2:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            add_cnt_q <= 0;
            mul_cnt_q <= 0;
        end else begin
            add_cnt_q <= add_cnt_d;
            mul_cnt_q <= mul_cnt_d;
        end
    end

    AST_STALL_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && stall) |-> (in_op ? (mul_cnt_q == MUL_RS) : (add_cnt_q == ADD_RS))); // R2
    AST_NO_STALL_WITH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op ? (mul_cnt_q < MUL_RS) : (add_cnt_q < ADD_RS))) |-> !stall); // R2
    AST_POOL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (add_cnt_q <= ADD_RS) && (mul_cnt_q <= MUL_RS)); // R3
    AST_BUSY_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(busy) == add_cnt_q + mul_cnt_q); // R10
    AST_WB_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> busy[wb_slot]); // R10
    AST_WB_FREES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !(accept && (in_op == wb_tag[TAG_W-1]))) |=> !busy[$past(wb_slot)]); // R10

endmodule

bind tomasulo_core tomasulo_core_chk #(
    .ADD_RS(ADD_RS),
    .MUL_RS(MUL_RS),
    .TAG_W (TAG_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_op   (in_op),
    .stall   (stall),
    .wb_valid(wb_valid),
    .wb_tag  (wb_tag),
    .busy    (rs_busy)
);

// File: tb/test_tomasulo_core.sv
module test_tomasulo_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_op = 1'b0;
    logic [2:0]  in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic        stall, wb_valid;
    logic [2:0]  wb_tag, wb_reg;
    logic [15:0] wb_value;

    always #2 clk = ~clk;   // 4 ns period

    tomasulo_core i_tomasulo_core (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .stall(stall),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_reg(wb_reg), .wb_value(wb_value)
    );

    int nvec = 0, nfail = 0, cyc = 0;
    logic [15:0] arch [8];
    bit   pv [8];
    int   ptag [8], preg [8], pcyc [8];
    logic [15:0] pval [8];
    int   lg_n = 0;
    int   lg_dc [256], lg_wc [256], lg_tag [256];
    logic [15:0] lg_val [256];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int free_slot(input bit op);
        int pool;
        bit used;
        pool = op ? 2 : 3;
        for (int k = 0; k < pool; k++) begin
            used = 0;
            for (int j = 0; j < 8; j++)
                if (pv[j] && ptag[j] == (op ? 4 + k : k)) used = 1;
            if (!used) return k;
        end
        return -1;
    endfunction

    function automatic int any_pending();
        int n = 0;
        for (int j = 0; j < 8; j++) if (pv[j]) n++;
        return n;
    endfunction

    // one cycle: drive at the falling edge, sample shortly after
    task automatic step(input bit v, input bit op, input int d, input int a, input int b,
                        output bit acc);
        int fi, k;
        bit hit;
        logic [15:0] ev;
        @(negedge clk);
        cyc++;
        in_valid = v; in_op = op;
        in_dst = 3'(d); in_src1 = 3'(a); in_src2 = 3'(b);
        #1;
        acc = 0;
        if (v) begin
            fi = free_slot(op);
            chk(stall === (fi < 0), "R2 stall", int'(stall), int'(fi < 0));
            if (stall === 1'b0) begin
                ev = op ? 16'(arch[a] * arch[b]) : 16'(arch[a] + arch[b]);
                arch[d] = ev;
                k = 0;
                while (k < 7 && pv[k]) k++;
                pv[k] = 1; ptag[k] = (fi < 0) ? -1 : (op ? 4 + fi : fi);
                preg[k] = d; pval[k] = ev; pcyc[k] = cyc;
                acc = 1;
            end
        end
        if (wb_valid === 1'b1) begin
            hit = 0;
            for (int j = 0; j < 8; j++) begin
                if (!hit && pv[j] && ptag[j] == int'(wb_tag)) begin
                    hit = 1;
                    chk(int'(wb_reg) == preg[j], "R5 destination", int'(wb_reg), preg[j]);
                    chk(wb_value === pval[j], "R5 value", int'(wb_value), int'(pval[j]));
                    if (lg_n < 256) begin
                        lg_dc[lg_n] = pcyc[j]; lg_wc[lg_n] = cyc;
                        lg_tag[lg_n] = int'(wb_tag); lg_val[lg_n] = wb_value;
                        lg_n++;
                    end
                    pv[j] = 0;
                end
            end
            chk(hit, "R3 tag of writeback", int'(wb_tag), -1);
        end
    endtask

    task automatic idle(input int n);
        bit acc;
        repeat (n) step(0, 0, 0, 0, 0, acc);
    endtask

    task automatic issue(input bit op, input int d, input int a, input int b, output int at);
        bit acc = 0;
        int n = 0;
        while (!acc && n < 50) begin
            step(1, op, d, a, b, acc);
            n++;
        end
        at = cyc;
    endtask

    task automatic drain();
        int n = 0;
        bit acc;
        while (any_pending() > 0 && n < 200) begin
            step(0, 0, 0, 0, 0, acc);
            n++;
        end
        chk(any_pending() == 0, "R5 all results written back", any_pending(), 0);
    endtask

    function automatic int wcyc_of(input int dc);
        for (int i = 0; i < lg_n; i++) if (lg_dc[i] == dc) return lg_wc[i];
        return -1;
    endfunction

    function automatic int wtag_of(input int dc);
        for (int i = 0; i < lg_n; i++) if (lg_dc[i] == dc) return lg_tag[i];
        return -1;
    endfunction

    function automatic int wval_of(input int dc);
        for (int i = 0; i < lg_n; i++) if (lg_dc[i] == dc) return int'(lg_val[i]);
        return -1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        in_valid = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int k = 0; k < 8; k++) begin
            arch[k] = 16'(k);
            pv[k] = 0;
        end
        cyc = 0;
        lg_n = 0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        #600000;
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        int c0, c1, c2, c3, c4;
        logic [15:0] lf;
        bit acc;

        // reset state
        do_reset();
        #1;
        chk(wb_valid === 1'b0, "R1 no writeback after reset", int'(wb_valid), 0);
        chk(stall === 1'b0, "R1 stall low after reset", int'(stall), 0);
        issue(0, 0, 6, 7, c0);
        drain();
        chk(wval_of(c0) == 13, "R1 register k holds k", wval_of(c0), 13);

        // latency of independent operations
        do_reset();
        issue(0, 1, 2, 3, c0);
        drain();
        chk(wcyc_of(c0) == c0 + 3, "R4 add latency", wcyc_of(c0), c0 + 3);
        issue(1, 2, 3, 4, c1);
        drain();
        chk(wcyc_of(c1) == c1 + 5, "R4 multiply latency", wcyc_of(c1), c1 + 5);
        chk(wval_of(c1) == 12, "R5 multiply value", wval_of(c1), 12);

        // dependent starts the cycle after the broadcast
        do_reset();
        issue(0, 1, 2, 3, c0);
        issue(1, 4, 1, 7, c1);
        drain();
        chk(wcyc_of(c1) == c0 + 8, "R6 dependent wakeup", wcyc_of(c1), c0 + 8);
        chk(wval_of(c1) == 35, "R5 renamed operand", wval_of(c1), 35);

        // oldest ready first: older waiter in station 1, younger in station 0
        do_reset();
        issue(1, 4, 1, 2, c0);
        issue(0, 7, 1, 1, c1);
        issue(0, 5, 4, 3, c2);
        idle(2);
        issue(0, 6, 4, 2, c3);
        drain();
        chk(c3 == c0 + 5, "R10 station reuse timing", c3, c0 + 5);
        chk(wtag_of(c2) == 1, "R3 first free station", wtag_of(c2), 1);
        chk(wtag_of(c3) == 0, "R3 freed lowest station", wtag_of(c3), 0);
        chk(wcyc_of(c2) == c0 + 8, "R7 older starts first", wcyc_of(c2), c0 + 8);
        chk(wcyc_of(c3) == c0 + 9, "R7 younger one cycle later", wcyc_of(c3), c0 + 9);
        chk(wcyc_of(c3) == c3 + 4, "R6 operand from same-cycle broadcast", wcyc_of(c3), c3 + 4);

        // bus collision, multiply older
        do_reset();
        issue(1, 4, 1, 2, c0);
        idle(1);
        issue(0, 6, 1, 1, c1);
        drain();
        chk(wcyc_of(c0) == c0 + 5, "R8 older multiply wins", wcyc_of(c0), c0 + 5);
        chk(wcyc_of(c1) == c0 + 6, "R8 younger add delayed", wcyc_of(c1), c0 + 6);

        // bus collision, add older
        do_reset();
        issue(1, 4, 1, 2, c0);
        issue(0, 5, 4, 1, c1);
        idle(1);
        issue(1, 6, 2, 3, c2);
        drain();
        chk(wcyc_of(c1) == c0 + 8, "R8 older add wins", wcyc_of(c1), c0 + 8);
        chk(wcyc_of(c2) == c0 + 9, "R8 younger multiply delayed", wcyc_of(c2), c0 + 9);

        // write-after-write: slow older producer must not overwrite
        do_reset();
        issue(1, 4, 2, 3, c0);
        issue(0, 4, 1, 1, c1);
        drain();
        issue(0, 5, 4, 0, c2);
        drain();
        chk(wval_of(c2) == 2, "R9 younger write kept", wval_of(c2), 2);

        // multiplier pool full: stall, then reuse of the first freed station
        do_reset();
        issue(1, 1, 1, 1, c0);
        issue(1, 2, 2, 2, c1);
        issue(1, 3, 3, 3, c2);
        drain();
        chk(c2 == c0 + 6, "R10 accepted after free", c2, c0 + 6);
        chk(wtag_of(c2) == 4, "R3 multiply station 0 reused", wtag_of(c2), 4);
        issue(0, 1, 1, 2, c3);
        issue(0, 2, 3, 3, c4);
        drain();
        chk(wval_of(c4) == 18, "R5 add of multiply result", wval_of(c4), 18);

        // pseudo-random sweep against the in-order model
        do_reset();
        lf = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0] | lf[1], lf[2], int'(lf[6:4]), int'(lf[9:7]), int'(lf[12:10]), acc);
        end
        drain();

        summary();
    end

endmodule